// File: doc/BRIEF.md
# Byte-Register SPI Flash Command Controller

This block lets software run one serial-flash command at a time over a small byte-wide register bus. Software loads a command byte into a dedicated register, packs the number of bytes to send and to fetch into a count register, and fills an eight-entry circular byte store through a data window. Each access to that window advances a visible three-bit pointer. Writing the control register with its run bit set starts the transfer. Software then polls the same bit until it drops.

On the wire the controller lowers chip select and sends the command byte. It then sends write-count plus read-count further bytes, each taken from the store at the current pointer. The byte returned by the flash for each of those bytes is written back into the slot it came from, and the pointer steps on. After the run, the reply bytes occupy the slots that follow the sent ones, modulo eight. Nothing ever clears the store. The SPI clock is the system clock divided by two, four, six or eight, picked by a two-bit field. The data window has no back-pressure: every access is taken in the cycle it is presented. While a transfer runs, register writes and data-window accesses are dropped.

Top module: `spi_flash_host`

## Requirements
- R1: After reset the command and count registers read 0, the control register reads 0, the status register at offset 0xD reads 0x30 (clock select 3, pointer 0), chip select is high and SCK is low.
- R2: A write to offset 0xC stores the byte at the pointer position and a read returns the byte there; either one then advances the pointer by one modulo 8. The pointer reads back in bits 2:0 of offset 0xD.
- R3: Writing offset 2 with bit 4 set while idle returns the pointer to 0.
- R4: Writing offset 2 with bit 0 set while idle starts a transfer; bit 0 of offset 2 reads 1 while chip select is low and 0 once it has been released.
- R5: A transfer sends the command byte of offset 0 and then write-count plus read-count bytes taken from the ring, starting at the pointer, MSB first in SPI mode 0 (SCK idles low, MOSI changes after a falling edge, MISO is sampled on a rising edge).
- R6: The byte received for each byte after the command is stored at the ring slot it was sent from, and the pointer ends at its start value plus write-count plus read-count, modulo 8.
- R7: With clock select S in bits 5:4 of offset 0xD, each SCK half-period lasts S+1 clocks, and chip select stays low for (S+1)*(16*(1+W+R)+1) clocks, which includes one half-period before the first edge and one after the last.
- R8: While a transfer runs, writes to offsets 0, 1, 0xC and 0xD, reads of 0xC, and pointer-reset requests change neither the registers, the ring nor the pointer.
- R9: A single control write with both bit 0 and bit 4 set clears the pointer first, so the transfer starts at slot 0.
- R10: Offset 1 reads back as written, with the read count in bits 7:4 and the write count in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the fastest SPI rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; needed only for data-window reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two functions can fall in the same cycle: the pointer reset and the transfer start, when one control write sets both bits. The bench first moves the pointer away from zero with data-window reads, then issues the combined write. The result is judged from the bytes seen on MOSI and from where the replies land in the ring: both must follow slot 0. The other same-cycle case is a bus access that arrives while the engine is storing a reply. This is provoked by accesses made during a slow transfer. It is judged by reading back the pointer, counts, clock select and every ring slot afterwards.

// File: rtl/spifh_pkg.sv
package spifh_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_OPC  = 4'h0;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'h1;
  localparam logic [ADDR_W-1:0] A_CTL  = 4'h2;
  localparam logic [ADDR_W-1:0] A_DATA = 4'hC;
  localparam logic [ADDR_W-1:0] A_STAT = 4'hD;

  localparam int CTL_RUN_BIT = 0;
  localparam int CTL_CLR_BIT = 4;
  localparam int SPD_LSB     = 4;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_HOLD = 2'd2
  } eng_st_e;
endpackage

// File: rtl/spifh_ring.sv
module spifh_ring #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic [PTR_W-1:0] ptr,
  output logic [DW-1:0]    cur_byte,
  output logic [DW-1:0]    nxt_byte
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] ptr_inc;

  assign ptr_inc  = (ptr == LAST) ? '0 : ptr + 1'b1;
  assign cur_byte = mem[ptr];
  assign nxt_byte = mem[ptr_inc];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (clr) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= ptr_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[ptr] <= wdata;
    end
  end
endmodule

// File: rtl/spifh_clkdiv.sv
module spifh_clkdiv #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [SEL_W-1:0] cnt;

  assign tick = run && (cnt == sel);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
    end else if (cnt == sel) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: with a divide ratio above one, ticks never come back to back
  p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/spifh_engine.sv
module spifh_engine
  import spifh_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LEFT_W = 5,
  localparam int BIT_W = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW-1:0]     opcode,
  input  logic [LEFT_W-1:0] nbytes,
  input  logic              tick,
  input  logic [DW-1:0]     cur_byte,
  input  logic [DW-1:0]     nxt_byte,
  input  logic              miso,
  output logic              busy,
  output logic              store,
  output logic [DW-1:0]     rx_byte,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi
);
  eng_st_e           st;
  logic [DW-1:0]     sh_tx;
  logic [DW-1:0]     sh_rx;
  logic [BIT_W-1:0]  bitcnt;
  logic [LEFT_W-1:0] left;
  logic              is_opc;
  logic              byte_end;

  assign busy     = (st != ENG_IDLE);
  assign mosi     = sh_tx[DW-1];
  assign rx_byte  = sh_rx;
  assign byte_end = (st == ENG_RUN) && tick && sck && (bitcnt == '0);
  assign store    = byte_end && !is_opc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ENG_IDLE;
      sck    <= 1'b0;
      cs_n   <= 1'b1;
      sh_tx  <= '0;
      sh_rx  <= '0;
      bitcnt <= '0;
      left   <= '0;
      is_opc <= 1'b0;
    end else begin
      unique case (st)
        ENG_IDLE: begin
          if (start) begin
            st     <= ENG_RUN;
            cs_n   <= 1'b0;
            sck    <= 1'b0;
            sh_tx  <= opcode;
            bitcnt <= BIT_W'(DW - 1);
            left   <= nbytes;
            is_opc <= 1'b1;
          end
        end
        ENG_RUN: begin
          if (tick) begin
            if (!sck) begin
              sck   <= 1'b1;
              sh_rx <= {sh_rx[DW-2:0], miso};
            end else begin
              sck <= 1'b0;
              if (bitcnt == '0) begin
                if (left == '0) begin
                  st <= ENG_HOLD;
                end else begin
                  sh_tx  <= is_opc ? cur_byte : nxt_byte;
                  left   <= left - 1'b1;
                  is_opc <= 1'b0;
                  bitcnt <= BIT_W'(DW - 1);
                end
              end else begin
                bitcnt <= bitcnt - 1'b1;
                sh_tx  <= {sh_tx[DW-2:0], 1'b0};
              end
            end
          end
        end
        ENG_HOLD: begin
          if (tick) begin
            cs_n <= 1'b1;
            st   <= ENG_IDLE;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  // R4: the busy indication and the chip select always agree
  p_cs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);
  // R5: SCK rests low whenever the flash is deselected
  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R5: MOSI is settled at every rising SCK edge
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
endmodule

// File: rtl/spi_flash_host.sv
module spi_flash_host
  import spifh_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int DW    = 8,
  parameter int SEL_W = 2,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int LEFT_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]      opc_q;
  logic [2*CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0]   spd_q;

  logic              busy, tick, eng_store;
  logic [DW-1:0]     rx_byte, cur_byte, nxt_byte;
  logic [PTR_W-1:0]  ptr;
  logic              idle_wr, ctl_wr, start, ptr_clr;
  logic              data_wr, data_acc;
  logic [LEFT_W-1:0] nbytes;

  assign idle_wr  = bus_wr && !busy;
  assign ctl_wr   = idle_wr && (bus_addr == A_CTL);
  assign start    = ctl_wr && bus_wdata[CTL_RUN_BIT];
  assign ptr_clr  = ctl_wr && bus_wdata[CTL_CLR_BIT];
  assign data_wr  = idle_wr && (bus_addr == A_DATA);
  assign data_acc = !busy && (bus_wr || bus_rd) && (bus_addr == A_DATA);
  assign nbytes   = LEFT_W'(cnt_q[CNT_W-1:0]) + LEFT_W'(cnt_q[2*CNT_W-1:CNT_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc_q <= '0;
      cnt_q <= '0;
      spd_q <= '1;
    end else if (idle_wr) begin
      if (bus_addr == A_OPC)  opc_q <= bus_wdata;
      if (bus_addr == A_CNT)  cnt_q <= bus_wdata[2*CNT_W-1:0];
      if (bus_addr == A_STAT) spd_q <= bus_wdata[SPD_LSB +: SEL_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_OPC:  bus_rdata = opc_q;
      A_CNT:  bus_rdata = DW'(cnt_q);
      A_CTL:  bus_rdata[CTL_RUN_BIT] = busy;
      A_DATA: bus_rdata = cur_byte;
      A_STAT: begin
        bus_rdata[PTR_W-1:0]           = ptr;
        bus_rdata[SPD_LSB +: SEL_W]    = spd_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  spifh_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ptr_clr),
    .adv      (data_acc || eng_store),
    .wr_en    (data_wr || eng_store),
    .wdata    (eng_store ? rx_byte : bus_wdata),
    .ptr      (ptr),
    .cur_byte (cur_byte),
    .nxt_byte (nxt_byte)
  );

  spifh_clkdiv #(.SEL_W(SEL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .sel   (spd_q),
    .tick  (tick)
  );

  spifh_engine #(.DW(DW), .LEFT_W(LEFT_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .opcode   (opc_q),
    .nbytes   (nbytes),
    .tick     (tick),
    .cur_byte (cur_byte),
    .nxt_byte (nxt_byte),
    .miso     (spi_miso),
    .busy     (busy),
    .store    (eng_store),
    .rx_byte  (rx_byte),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi)
  );

  // R8: during a transfer only the engine moves the pointer
  p_ptr_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !eng_store) |=> $stable(ptr));
  // R6: each stored reply steps the pointer by exactly one slot
  p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_store |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
  // R8: the count register cannot change while busy
  p_cnt_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cnt_q));
endmodule

// File: tb/sim_spi_flash_host.sv
`timescale 1ns/1ps
module sim_spi_flash_host;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  spi_flash_host u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash model: replies with a seeded byte per byte index
  logic [7:0] sl_seed = 8'h00;
  logic [7:0] cap [32];
  logic [7:0] sl_sh = '0;
  int sl_idx = 0;
  int sl_bit = 0;
  logic pcs = 1'b1;
  logic psck = 1'b0;

  function automatic logic [7:0] resp(input logic [7:0] sd, input int i);
    return sd ^ 8'(i * 29 + 3);
  endfunction

  always @(spi_cs_n or spi_sck) begin
    logic [7:0] t;
    if (pcs && !spi_cs_n) begin
      sl_idx = 0; sl_bit = 0;
      t = resp(sl_seed, 0); spi_miso = t[7];
    end
    if (!psck && spi_sck) begin
      sl_sh = {sl_sh[6:0], spi_mosi};
      if (sl_bit == 7 && sl_idx < 32) cap[sl_idx] = sl_sh;
    end
    if (psck && !spi_sck && !spi_cs_n) begin
      if (sl_bit == 7) begin sl_bit = 0; sl_idx++; end
      else sl_bit++;
      t = resp(sl_seed, sl_idx); spi_miso = t[7 - sl_bit];
    end
    pcs = spi_cs_n; psck = spi_sck;
  end

  // chip select low time in clocks
  int cs_cnt = 0;
  logic cs_was_low = 1'b0;
  always @(posedge clk) begin
    if (!spi_cs_n) cs_cnt = cs_was_low ? cs_cnt + 1 : 1;
    cs_was_low = !spi_cs_n;
  end

  // bench model of the ring
  logic [7:0] mdl [8];
  int mptr = 0;
  logic [7:0] exp_tx [32];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic preload(input logic [7:0] sd);
    wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'(8'h11 * i) ^ sd;
      wr(4'hC, v);
      mdl[i] = v;
    end
    mptr = 0;
  endtask

  task automatic predict(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      exp_tx[i] = mdl[(p + i) % 8];
      mdl[(p + i) % 8] = resp(sl_seed, i + 1);
    end
    mptr = (p + n) % 8;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] d;
    int guard;
    rd(4'h2, d);
    chk({tag, " R4 busy after start"}, int'(d[0]), 1);
    guard = 0;
    while (d[0] && guard < 5000) begin
      rd(4'h2, d);
      guard++;
    end
    chk({tag, " R4 busy cleared"}, int'(d[0]), 0);
    chk({tag, " R4 cs released"}, int'(spi_cs_n), 1);
  endtask

  task automatic check_after(input string tag, input logic [7:0] opc, input int n, input int spd);
    logic [7:0] d;
    chk({tag, " R7 cs low clocks"}, cs_cnt, (spd + 1) * (16 * (1 + n) + 1));
    chk({tag, " R5 opcode on wire"}, int'(cap[0]), int'(opc));
    for (int i = 0; i < n; i++)
      chk({tag, " R5 data byte on wire"}, int'(cap[i + 1]), int'(exp_tx[i]));
    rd(4'hD, d);
    chk({tag, " R6 end pointer"}, int'(d[2:0]), mptr);
    wr(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      rd(4'hC, d);
      chk({tag, " R6 ring slot"}, int'(d), int'(mdl[i]));
    end
    mptr = 0;
  endtask

  task automatic t_xfer(input string tag, input logic [7:0] opc, input int w, input int r,
                        input int spd, input logic [7:0] sd, input int moves, input bit clr_go);
    logic [7:0] d;
    int p;
    preload(sd ^ 8'h5C);
    for (int k = 0; k < moves; k++) begin rd(4'hC, d); mptr = (mptr + 1) % 8; end
    sl_seed = sd;
    wr(4'hD, 8'(spd << 4));
    wr(4'h0, opc);
    wr(4'h1, {4'(r), 4'(w)});
    p = clr_go ? 0 : mptr;
    predict(p, w + r);
    wr(4'h2, clr_go ? 8'h11 : 8'h01);
    wait_idle(tag);
    check_after(tag, opc, w + r, spd);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(4'h0, d); chk("R1 command reg", int'(d), 0);
    rd(4'h1, d); chk("R1 count reg", int'(d), 0);
    rd(4'h2, d); chk("R1 control reg", int'(d), 0);
    rd(4'hD, d); chk("R1 status reg", int'(d), 8'h30);
    chk("R1 cs high", int'(spi_cs_n), 1);
    chk("R1 sck low", int'(spi_sck), 0);
  endtask

  task automatic t_window;
    logic [7:0] d;
    preload(8'hA7);
    rd(4'hD, d); chk("R2 pointer wrapped after 8 writes", int'(d[2:0]), 0);
    for (int i = 0; i < 3; i++) begin
      rd(4'hC, d); chk("R2 data read", int'(d), int'(mdl[i]));
    end
    rd(4'hD, d); chk("R2 pointer after 3 reads", int'(d[2:0]), 3);
    wr(4'hC, 8'h9E); mdl[3] = 8'h9E;
    rd(4'hD, d); chk("R2 pointer after write", int'(d[2:0]), 4);
    wr(4'h2, 8'h10);
    rd(4'hD, d); chk("R3 pointer cleared", int'(d[2:0]), 0);
    for (int i = 0; i < 4; i++) rd(4'hC, d);
    chk("R2 written byte read back", int'(d), 8'h9E);
    wr(4'h1, 8'hB6);
    rd(4'h1, d); chk("R10 count packing", int'(d), 8'hB6);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] d;
    preload(8'h3D);
    sl_seed = 8'hC4;
    wr(4'hD, 8'h30);
    wr(4'h0, 8'h0B);
    wr(4'h1, 8'h22);
    predict(0, 4);
    wr(4'h2, 8'h01);
    wr(4'h1, 8'hFF);
    wr(4'h0, 8'h77);
    wr(4'hC, 8'hEE);
    rd(4'hC, d);
    wr(4'hD, 8'h00);
    wr(4'h2, 8'h10);
    wait_idle("busy");
    rd(4'h1, d); chk("R8 count kept", int'(d), 8'h22);
    rd(4'h0, d); chk("R8 command kept", int'(d), 8'h0B);
    rd(4'hD, d); chk("R8 clock select kept", int'(d[5:4]), 3);
    check_after("busy R8", 8'h0B, 4, 3);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_xfer("basic",   8'h02, 3, 2, 0, 8'h61, 0, 1'b0);
    t_xfer("wrap",    8'h0B, 5, 6, 1, 8'h92, 3, 1'b0);
    t_xfer("clr+go R9", 8'h03, 0, 4, 2, 8'h1F, 5, 1'b1);
    t_xfer("opc only", 8'h06, 0, 0, 3, 8'hE3, 2, 1'b0);
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule